// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block guards a small microcontroller against runaway software. It runs from its own slow, free-running clock. That clock is separate from the system clock, so the watchdog keeps counting while the core sleeps. A prescaler divides the watchdog clock by 2^N, where a 4-bit select field gives N. The prescaler feeds an 8-bit up-counter. When the counter wraps from 255 to 0, the block sends out a chip reset request for two watchdog clock cycles. It also sets a sticky cause flag that software can read after the restart.

Software controls the block through one small control register in the system clock domain. The register holds an enable bit, a 4-bit period select, a time-out flag and a "kick" strobe. The kick strobe zeroes both the counter and the prescaler. A non-volatile option input forces the watchdog inactive whatever the enable bit holds. Register settings reach the watchdog clock through two-flop synchronisers. The overflow event returns to the system domain through a toggle synchroniser. That event clears the enable bit, restores the default period and sets the flag.

Top module: `wdt_core`

## Requirements
- R1: After the external reset (`rst_n` low), `rd_data` reads 7'h04 and `wd_rst_req` is low. In `rd_data`, bit 6 is the enable, bit 5 is the flag, bit 4 reads 0 and bits 3:0 are the select, which defaults to 4'b0100.
- R2: With the block enabled, select N and the option input low, `wd_rst_req` rises 256·2^N watchdog clock cycles after the enabling write, plus up to 5 cycles of synchroniser latency.
- R3: Each reset request is a single high pulse on `wd_rst_req` lasting exactly 2 watchdog clock cycles.
- R4: A write with bit 4 set (the kick) zeroes the counter and the prescaler. Kicks repeated more often than the period prevent any request, and the next time-out falls a full period after the last kick.
- R5: While `opt_off` is 1, no request is produced and the enable bit still reads back as written. When `opt_off` returns to 0, a full period starts from zero.
- R6: After a time-out, once the system clock runs, `rd_data` shows the flag set, the enable cleared and the select back at 4'b0100 (7'h24).
- R7: Writing 1 to bit 5 clears the flag. Writing 0 to bit 5 leaves the flag unchanged.
- R8: Changing the select while the block runs restarts the prescaler and the counter, so the next time-out lies a full new period after the change.
- R9: The external reset clears the time-out flag.
- R10: With the system clock stopped, the watchdog still times out and pulses `wd_rst_req`. The flag shows up once the system clock resumes.
- R11: Writing enable 0 stops the count and zeroes it. Re-enabling starts a full period from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped during sleep |
| rst_n | input | 1 | External reset, active low, asynchronous |
| wd_clk | input | 1 | Free-running watchdog clock |
| opt_off | input | 1 | Non-volatile option; 1 forces the watchdog inactive |
| wr_en | input | 1 | Control register write strobe (clk domain) |
| wr_data | input | 7 | Write data: [6] enable, [5] flag write-1-to-clear, [4] kick, [3:0] select |
| rd_data | output | 7 | Read data: [6] enable, [5] flag, [4] zero, [3:0] select |
| wd_rst_req | output | 1 | Reset request, 2 watchdog clock cycles high |

## Verification
A wrong prescaler mask or counter step moves the rising edge of `wd_rst_req` out of its window. At select 0 that shows within a few hundred watchdog cycles. A kick, select change or enable path that fails to clear state produces a request that comes too early, or one that nobody expected. A broken return path shows within a handful of system cycles of the pulse: `rd_data` then fails to report the flag set, the enable cleared and the select restored. A stuck pulse counter shows up as a pulse width other than two.

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4,
  parameter int REQ_CYC = 2,
  parameter logic [SEL_W-1:0] SEL_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_clk,
  input  logic             opt_off,
  input  logic             wr_en,
  input  logic [SEL_W+2:0] wr_data,
  output logic [SEL_W+2:0] rd_data,
  output logic             wd_rst_req
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam int REQ_W = $clog2(REQ_CYC + 1);
  localparam int B_EN = SEL_W + 2;
  localparam int B_FLG = SEL_W + 1;
  localparam int B_KICK = SEL_W;

  // system clock domain
  logic             en_q, flg_q, kick_t;
  logic [SEL_W-1:0] sel_q;
  logic [2:0]       ov_s;
  logic             ov_t;
  wire              trip = ov_s[2] ^ ov_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; flg_q <= 1'b0; kick_t <= 1'b0;
      sel_q <= SEL_RST; ov_s <= '0;
    end else begin
      ov_s <= {ov_s[1:0], ov_t};
      if (trip) begin
        en_q  <= 1'b0;
        flg_q <= 1'b1;
        sel_q <= SEL_RST;
      end else if (wr_en) begin
        en_q  <= wr_data[B_EN];
        sel_q <= wr_data[SEL_W-1:0];
        if (wr_data[B_FLG])  flg_q <= 1'b0;
        if (wr_data[B_KICK]) kick_t <= ~kick_t;
      end
    end

  assign rd_data = {en_q, flg_q, 1'b0, sel_q};

  // watchdog clock domain
  logic [1:0]       run_s;
  logic [SEL_W-1:0] sel_m, sel_w, sel_l;
  logic [2:0]       kick_s;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic             halt;
  logic [REQ_W-1:0] req_n;

  wire             restart = !run_s[1] || halt || (kick_s[2] ^ kick_s[1]) || (sel_w != sel_l);
  wire [PRE_W-1:0] mask    = (PRE_W'(1) << sel_w) - 1'b1;
  wire             tick    = (pre & mask) == mask;
  wire             ov      = !restart && tick && (cnt == '1);

  always_ff @(posedge wd_clk or negedge rst_n)
    if (!rst_n) begin
      run_s <= '0; kick_s <= '0;
      sel_m <= SEL_RST; sel_w <= SEL_RST; sel_l <= SEL_RST;
      pre <= '0; cnt <= '0; halt <= 1'b0; ov_t <= 1'b0; req_n <= '0;
    end else begin
      run_s  <= {run_s[0], en_q & ~opt_off};
      sel_m  <= sel_q;
      sel_w  <= sel_m;
      sel_l  <= sel_w;
      kick_s <= {kick_s[1:0], kick_t};
      if (restart) begin
        pre <= '0;
        cnt <= '0;
      end else begin
        pre <= pre + 1'b1;
        if (tick) cnt <= cnt + 1'b1;
      end
      if (ov) halt <= 1'b1;
      else if (!run_s[1]) halt <= 1'b0;
      if (ov) ov_t <= ~ov_t;
      if (ov) req_n <= REQ_W'(REQ_CYC);
      else if (req_n != '0) req_n <= req_n - 1'b1;
    end

  assign wd_rst_req = req_n != '0;

  p_req_two_cyc_r3: assert property (@(posedge wd_clk) disable iff (!rst_n)
    $rose(wd_rst_req) |=> wd_rst_req);
  p_req_ends_r3: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (wd_rst_req && $past(wd_rst_req)) |=> !wd_rst_req);
  p_idle_zero_r11: assert property (@(posedge wd_clk) disable iff (!rst_n)
    !run_s[1] |=> (cnt == '0 && pre == '0));
  p_step_r2: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));
  p_trip_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (flg_q && !en_q && sel_q == SEL_RST));
endmodule

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
  logic clk = 1'b0, wd_clk = 1'b0, clk_on = 1'b1;
  logic rst_n = 1'b0, opt_off = 1'b0, wr_en = 1'b0;
  logic [6:0] wr_data = '0;
  logic [6:0] rd_data;
  logic wd_rst_req;

  always #5 clk = clk_on ? ~clk : clk;
  always #15 wd_clk = ~wd_clk;

  wdt_core u_dut (.clk(clk), .rst_n(rst_n), .wd_clk(wd_clk), .opt_off(opt_off),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .wd_rst_req(wd_rst_req));

  typedef struct { int start; int lo; int hi; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, wcyc = 0, pulses = 0;
  bit done = 0;

  always @(posedge wd_clk) wcyc <= wcyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic expect_trip(input int t, input string tag);
    exp_t e;
    e.start = wcyc; e.lo = t; e.hi = t + 5; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wwait(input int n);
    repeat (n) @(posedge wd_clk);
  endtask

  // monitor: compares observed pulses with the queue
  logic prev = 1'b0;
  int width = 0;
  always @(negedge wd_clk) begin
    if (wd_rst_req && !prev) begin
      pulses++;
      width = 1;
      if (q.size() == 0) chk(1'b0, "R5 unexpected request", wcyc, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk((wcyc - e.start) >= e.lo && (wcyc - e.start) <= e.hi, e.tag, wcyc - e.start, e.lo);
      end
    end else if (wd_rst_req) width++;
    else if (prev) chk(width == 2, "R3 pulse width", width, 2);
    prev = wd_rst_req;
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int p;
    #37 rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 7'h04, "R1 reset value", rd_data, 7'h04);
    chk(wd_rst_req == 1'b0, "R1 request low", wd_rst_req, 0);

    // R2 select 0
    wr(7'h40); expect_trip(256, "R2 sel0 period");
    wwait(300);
    chk(pulses == 1, "R2 one request", pulses, 1);
    chk(rd_data == 7'h24, "R6 flag set enable off select default", rd_data, 7'h24);

    // R7 flag clearing
    wr(7'h04);
    chk(rd_data == 7'h24, "R7 write 0 keeps flag", rd_data, 7'h24);
    wr(7'h24);
    chk(rd_data == 7'h04, "R7 write 1 clears flag", rd_data, 7'h04);

    // R2 select 2
    wr(7'h42); expect_trip(1024, "R2 sel2 period");
    wwait(1100);
    chk(pulses == 2, "R2 sel2 request", pulses, 2);
    wr(7'h24);

    // R4 kick
    wr(7'h40);
    for (int i = 0; i < 4; i++) begin wwait(150); wr(7'h50); end
    expect_trip(256, "R4 period after last kick");
    wwait(100);
    chk(pulses == 2, "R4 kicks prevent request", pulses, 2);
    wwait(200);
    chk(pulses == 3, "R4 request after kicks stop", pulses, 3);
    wr(7'h24);

    // R8 select change restarts
    wr(7'h40); wwait(200);
    wr(7'h41); expect_trip(512, "R8 restart on select change");
    wwait(560);
    chk(pulses == 4, "R8 request", pulses, 4);
    wr(7'h24);

    // R5 option off
    @(negedge clk); opt_off = 1'b1;
    wr(7'h40); wwait(700);
    chk(pulses == 4, "R5 no request with option", pulses, 4);
    chk(rd_data == 7'h40, "R5 enable reads back", rd_data, 7'h40);
    @(negedge clk); opt_off = 1'b0; expect_trip(256, "R5 full period after release");
    wwait(300);
    chk(pulses == 5, "R5 request after release", pulses, 5);
    wr(7'h24);

    // R10 sleep
    wr(7'h40); expect_trip(256, "R10 period in sleep");
    @(negedge clk); clk_on = 1'b0;
    wwait(300);
    chk(pulses == 6, "R10 request while clock stopped", pulses, 6);
    clk_on = 1'b1;
    repeat (6) @(negedge clk);
    chk(rd_data == 7'h24, "R10 flag after wake", rd_data, 7'h24);

    // R9 external reset clears flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 7'h04, "R9 flag cleared by reset", rd_data, 7'h04);

    // R11 disable zeroes count
    wr(7'h40); wwait(200);
    wr(7'h00); wwait(400);
    chk(pulses == 6, "R11 disabled no request", pulses, 6);
    wr(7'h40); expect_trip(256, "R11 full period after re-enable");
    p = pulses;
    wwait(300);
    chk(pulses == p + 1, "R11 request after re-enable", pulses, p + 1);

    chk(q.size() == 0, "R2 all expected requests seen", q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule